// File: doc/BRIEF.md
# Timer/Counter with Shared Watchdog Prescaler

This block holds an 8-bit up-counter for a small controller and the time-base of that controller's watchdog. The counter steps either on an internal instruction-cycle strobe or on edges of an external pin. The external pin passes through a synchronizer, and a configuration bit chooses whether its rising or its falling edge counts. When the counter wraps from its all-ones value to zero, a one-cycle overflow pulse is raised, which the surrounding logic uses to set the timer interrupt flag. A bus write loads the counter directly.

A single power-of-two prescaler is shared between the two users. When the timer owns the prescaler, the 3-bit rate field divides by 2^(rate+1), from 1:2 to 1:256. The watchdog then steps on every tick. When the watchdog owns the prescaler, the same field divides by 2^rate, from 1:1 to 1:128, and the timer runs at 1:1. The watchdog counts ticks of a separate free-running tick input. Each time its count wraps, it produces a one-cycle time-out pulse and drops an active-low status bit. The clear command restores the status bit and restarts the count, and the sleep command does the same.

The four configuration bits sit in a small option register inside the block. This register is written through a one-cycle write strobe and comes out of reset with every bit set.

Top module: `tw_timer_wdt`

## Requirements
- R1: After reset the counter reads 0, the overflow and time-out pulses are low and the time-out status `wdt_to_n` is 1. The option register holds all ones: external pin source, falling edge, prescaler owned by the watchdog, rate 7.
- R2: With `cfg_src_ext`=1 the counter steps only on synchronized edges of `ext_pin`, and `cyc_stb` has no effect. With `cfg_src_ext`=0 it steps only on `cyc_stb` cycles, and `ext_pin` has no effect.
- R3: With the external source, `cfg_fall_edge`=1 counts high-to-low transitions of `ext_pin` only. `cfg_fall_edge`=0 counts low-to-high transitions only.
- R4: With `cfg_ps_wdt`=0 the counter advances once for every 2^(`cfg_rate`+1) source events.
- R5: With `cfg_ps_wdt`=1 the counter advances once for every source event (1:1).
- R6: The counter steps by exactly one. Stepping from FFh to 00h raises `tmr_ovf` for exactly the cycle in which the counter first reads 00h.
- R7: A cycle with `tmr_we`=1 loads `tmr_wdata` into the counter, with priority over stepping and without an overflow pulse. While `cfg_ps_wdt`=0 the write also empties the prescaler, so a full ratio of events is needed for the next step.
- R8: The watchdog counter is `WDT_W` bits wide and wraps after 2^`WDT_W` watchdog events. On the wrap, `wdt_timeout` is high for one cycle and `wdt_to_n` falls to 0 in that same cycle.
- R9: With `cfg_ps_wdt`=1 one watchdog event occurs every 2^`cfg_rate` pulses of `wdt_tick`. With `cfg_ps_wdt`=0 every `wdt_tick` pulse is an event.
- R10: `wdt_clr` or `sleep_cmd` restarts the watchdog count, suppresses a time-out in that cycle and sets `wdt_to_n` to 1. While `cfg_ps_wdt`=1 it also empties the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_stb | input | 1 | Internal instruction-cycle strobe |
| ext_pin | input | 1 | Asynchronous external count pin |
| cfg_we | input | 1 | Option register write strobe |
| cfg_src_ext | input | 1 | Source select: 1 pin, 0 strobe |
| cfg_fall_edge | input | 1 | Pin edge: 1 falling, 0 rising |
| cfg_ps_wdt | input | 1 | Prescaler owner: 1 watchdog, 0 timer |
| cfg_rate | input | 3 | Prescaler rate field |
| tmr_we | input | 1 | Counter write strobe |
| tmr_wdata | input | CNT_W | Counter write data |
| wdt_tick | input | 1 | Free-running watchdog tick |
| wdt_clr | input | 1 | Watchdog clear command |
| sleep_cmd | input | 1 | Sleep command, also clears the watchdog |
| tmr_q | output | CNT_W | Counter value |
| tmr_ovf | output | 1 | One-cycle overflow pulse |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |
| wdt_to_n | output | 1 | Time-out status, 0 after a time-out |

## Verification
The bench builds the block with `CNT_W`=8, `SYNC_N`=2 and `WDT_W`=4. With the 4-bit watchdog, a time-out comes after 16 events. This makes even the reset-default 1:128 watchdog ratio (2048 ticks) reachable, so the reset value of the rate field is checked through its effect. Keeping the counter at 8 bits allows the 1:256 timer ratio and the FFh-to-00h wrap to be checked after a load of FEh.

// File: rtl/tw_pkg.sv
// Package: shared constants, the option-register layout and the
// prescaler ratio helper used by the timer/watchdog block.
package tw_pkg;

    localparam int RATE_W  = 3;
    localparam int PRE_W   = 1 << RATE_W;        // widest ratio is 2^PRE_W
    localparam int SHIFT_W = $clog2(PRE_W + 1);  // holds 0..PRE_W

    typedef struct packed {
        logic              src_ext;
        logic              fall_edge;
        logic              ps_wdt;
        logic [RATE_W-1:0] rate;
    } tw_cfg_t;

    localparam tw_cfg_t CFG_RESET = '1;

    // Low-bit mask that is all ones once a 2^sh ratio is complete.
    function automatic logic [PRE_W-1:0] ratio_mask(input logic [SHIFT_W-1:0] sh);
        ratio_mask = ~({PRE_W{1'b1}} << sh);
    endfunction

endpackage

// File: rtl/tw_edge_sync.sv
// Edge synchronizer: brings an asynchronous pin into the clock domain
// through SYNC_N flops, then forms rise/fall pulses from the synced
// level and picks one of them. Assumes SYNC_N >= 2.
module tw_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_evt
);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              rise_w;
    logic              fall_w;

    // Shift the pin through the synchronizer and keep one history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    // Edge pulses from the synchronized level, then the edge choice.
    always_comb begin
        rise_w   = sync_q[SYNC_N-1] & ~prev_q;
        fall_w   = ~sync_q[SYNC_N-1] & prev_q;
        edge_evt = fall_sel ? fall_w : rise_w;
    end

endmodule

// File: rtl/tw_prescaler.sv
// Shared prescaler: counts input events and passes every 2^shift-th one.
// A shift of 0 passes every event. Clear empties the count.
// Assumes shift <= PRE_W.
module tw_prescaler
    import tw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_evt,
    input  logic               clr,
    input  logic [SHIFT_W-1:0] shift,
    output logic               out_evt
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask_w;

    // Pass the event that completes the selected ratio.
    always_comb begin
        mask_w  = ratio_mask(shift);
        out_evt = in_evt && ((cnt_q & mask_w) == mask_w);
    end

    // Free-running event count, emptied on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (in_evt) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/tw_counter.sv
// Timer counter: loadable up-counter with a registered wrap pulse.
// A load wins over a step and never produces a wrap pulse.
module tw_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] q,
    output logic             ovf
);

    // Load, step and wrap-pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            ovf <= 1'b0;
        end else if (we) begin
            q   <= wdata;
            ovf <= 1'b0;
        end else begin
            ovf <= inc && (&q);
            if (inc) q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/tw_watchdog.sv
// Watchdog counter: counts events and pulses a time-out on each wrap.
// Also holds an active-low status bit. A kick restarts the count and
// sets the status bit again.
module tw_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic kick,
    output logic timeout,
    output logic to_n
);

    logic [WDT_W-1:0] cnt_q;

    // Count, time-out pulse and status; the kick has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
            to_n    <= 1'b1;
        end else if (kick) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
            to_n    <= 1'b1;
        end else begin
            timeout <= evt && (&cnt_q);
            if (evt) cnt_q <= cnt_q + 1'b1;
            if (evt && (&cnt_q)) to_n <= 1'b0;
        end
    end

endmodule

// File: rtl/tw_timer_wdt.sv
// Top: option register, source/edge selection, shared prescaler steering,
// timer counter and watchdog. The prescaler owner sees the 2^n ratio;
// the other user runs at 1:1.
module tw_timer_wdt
    import tw_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WDT_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_stb,
    input  logic              ext_pin,
    input  logic              cfg_we,
    input  logic              cfg_src_ext,
    input  logic              cfg_fall_edge,
    input  logic              cfg_ps_wdt,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              tmr_we,
    input  logic [CNT_W-1:0]  tmr_wdata,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    input  logic              sleep_cmd,
    output logic [CNT_W-1:0]  tmr_q,
    output logic              tmr_ovf,
    output logic              wdt_timeout,
    output logic              wdt_to_n
);

    tw_cfg_t            cfg_q;
    logic               pin_evt;
    logic               src_evt;
    logic               wdt_kick;
    logic               pre_in;
    logic               pre_clr;
    logic               pre_out;
    logic [SHIFT_W-1:0] pre_shift;
    logic               tmr_inc;
    logic               wdt_evt;

    // Option register, every bit set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_we) cfg_q <= '{src_ext: cfg_src_ext, fall_edge: cfg_fall_edge,
                                    ps_wdt: cfg_ps_wdt, rate: cfg_rate};
    end

    tw_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_pin),
        .fall_sel (cfg_q.fall_edge),
        .edge_evt (pin_evt)
    );

    // Steer the shared prescaler between timer and watchdog.
    always_comb begin
        src_evt   = cfg_q.src_ext ? pin_evt : cyc_stb;
        wdt_kick  = wdt_clr | sleep_cmd;
        pre_in    = cfg_q.ps_wdt ? wdt_tick : src_evt;
        pre_clr   = cfg_q.ps_wdt ? wdt_kick : tmr_we;
        pre_shift = cfg_q.ps_wdt ? SHIFT_W'(cfg_q.rate)
                                 : SHIFT_W'(cfg_q.rate) + SHIFT_W'(1);
        tmr_inc   = cfg_q.ps_wdt ? src_evt  : pre_out;
        wdt_evt   = cfg_q.ps_wdt ? pre_out  : wdt_tick;
    end

    tw_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_evt  (pre_in),
        .clr     (pre_clr),
        .shift   (pre_shift),
        .out_evt (pre_out)
    );

    tw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (tmr_inc),
        .we    (tmr_we),
        .wdata (tmr_wdata),
        .q     (tmr_q),
        .ovf   (tmr_ovf)
    );

    tw_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (wdt_evt),
        .kick    (wdt_kick),
        .timeout (wdt_timeout),
        .to_n    (wdt_to_n)
    );

endmodule

// File: rtl/tw_timer_wdt_chk.sv
// Checker: temporal properties on the top-level ports of tw_timer_wdt.
// Attached by the bind statement at the end of this file.
module tw_timer_wdt_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_we,
    input logic [CNT_W-1:0] tmr_wdata,
    input logic [CNT_W-1:0] tmr_q,
    input logic             tmr_ovf,
    input logic             wdt_clr,
    input logic             sleep_cmd,
    input logic             wdt_timeout,
    input logic             wdt_to_n
);

    // R7
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_we |=> (tmr_q == $past(tmr_wdata)) && !tmr_ovf);

    // R6
    tmr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |-> (tmr_q == '0) && ($past(tmr_q) == '1));

    // R6
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_we) && (tmr_q != $past(tmr_q)))
            |-> (tmr_q == CNT_W'($past(tmr_q) + 1'b1)));

    // R8
    wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> !wdt_timeout);

    // R8
    wdt_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |-> !wdt_to_n);

    // R10
    wdt_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_clr || sleep_cmd) |=> wdt_to_n && !wdt_timeout);

endmodule

bind tw_timer_wdt tw_timer_wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_we      (tmr_we),
    .tmr_wdata   (tmr_wdata),
    .tmr_q       (tmr_q),
    .tmr_ovf     (tmr_ovf),
    .wdt_clr     (wdt_clr),
    .sleep_cmd   (sleep_cmd),
    .wdt_timeout (wdt_timeout),
    .wdt_to_n    (wdt_to_n)
);

// File: tb/tw_timer_wdt_test.sv
// Directed bench: one task per scenario, each checking its own results.
module tw_timer_wdt_test;

    localparam int CNT_W = 8;
    localparam int WDT_W = 4;
    localparam int WDT_N = 1 << WDT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cyc_stb = 1'b0;
    logic             ext_pin = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_src_ext = 1'b0;
    logic             cfg_fall_edge = 1'b0;
    logic             cfg_ps_wdt = 1'b0;
    logic [2:0]       cfg_rate = 3'd0;
    logic             tmr_we = 1'b0;
    logic [CNT_W-1:0] tmr_wdata = '0;
    logic             wdt_tick = 1'b0;
    logic             wdt_clr = 1'b0;
    logic             sleep_cmd = 1'b0;
    logic [CNT_W-1:0] tmr_q;
    logic             tmr_ovf;
    logic             wdt_timeout;
    logic             wdt_to_n;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tw_timer_wdt #(.CNT_W(CNT_W), .WDT_W(WDT_W), .SYNC_N(2)) uut (
        .clk (clk), .rst_n (rst_n), .cyc_stb (cyc_stb), .ext_pin (ext_pin),
        .cfg_we (cfg_we), .cfg_src_ext (cfg_src_ext), .cfg_fall_edge (cfg_fall_edge),
        .cfg_ps_wdt (cfg_ps_wdt), .cfg_rate (cfg_rate), .tmr_we (tmr_we),
        .tmr_wdata (tmr_wdata), .wdt_tick (wdt_tick), .wdt_clr (wdt_clr),
        .sleep_cmd (sleep_cmd), .tmr_q (tmr_q), .tmr_ovf (tmr_ovf),
        .wdt_timeout (wdt_timeout), .wdt_to_n (wdt_to_n)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic src, input logic fall, input logic psw, input logic [2:0] rate);
        @(negedge clk);
        cfg_src_ext = src; cfg_fall_edge = fall; cfg_ps_wdt = psw; cfg_rate = rate;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input int n);
        if (n > 0) begin
            @(negedge clk);
            cyc_stb = 1'b1;
            repeat (n) @(negedge clk);
            cyc_stb = 1'b0;
        end
    endtask

    task automatic write_tmr(input logic [CNT_W-1:0] v);
        @(negedge clk);
        tmr_wdata = v; tmr_we = 1'b1;
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        ext_pin = v;
        repeat (6) @(negedge clk);
    endtask

    // Pulse wdt_tick n times; return how many time-out pulses were seen.
    task automatic ticks(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wdt_tick = 1'b1;
            @(negedge clk); wdt_tick = 1'b0;
            if (wdt_timeout) seen++;
        end
    endtask

    task automatic kick(input logic use_sleep);
        @(negedge clk);
        if (use_sleep) sleep_cmd = 1'b1; else wdt_clr = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0; wdt_clr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "tmr_q", int'(tmr_q), 0);
        chk("R1", "tmr_ovf", int'(tmr_ovf), 0);
        chk("R1", "wdt_timeout", int'(wdt_timeout), 0);
        chk("R1", "wdt_to_n", int'(wdt_to_n), 1);
        // Reset option: external source, falling edge, timer 1:1.
        strobe(10);
        chk("R1", "strobe ignored after reset", int'(tmr_q), 0);
        pin_to(1'b1);
        chk("R1", "rising edge ignored after reset", int'(tmr_q), 0);
        pin_to(1'b0);
        chk("R1", "falling edge counts 1:1 after reset", int'(tmr_q), 1);
    endtask

    task automatic t_reset_wdt_rate;
        int seen;
        // Reset option gives the watchdog a 1:128 ratio.
        kick(1'b0);
        ticks(128 * WDT_N - 1, seen);
        chk("R1", "no time-out before 128*16 ticks", seen, 0);
        ticks(1, seen);
        chk("R1", "time-out at 128*16 ticks", seen, 1);
        chk("R8", "to_n after time-out", int'(wdt_to_n), 0);
        @(negedge clk);
        chk("R8", "time-out pulse one cycle", int'(wdt_timeout), 0);
    endtask

    task automatic t_source_edge;
        logic [CNT_W-1:0] base;
        set_cfg(1'b1, 1'b0, 1'b1, 3'd7);
        base = tmr_q;
        pin_to(1'b1);
        chk("R3", "rising edge counted", int'(tmr_q), int'(base) + 1);
        pin_to(1'b0);
        chk("R3", "falling edge ignored", int'(tmr_q), int'(base) + 1);
        strobe(5);
        chk("R2", "strobe ignored with pin source", int'(tmr_q), int'(base) + 1);
        set_cfg(1'b0, 1'b0, 1'b1, 3'd7);
        base = tmr_q;
        pin_to(1'b1);
        pin_to(1'b0);
        chk("R2", "pin ignored with strobe source", int'(tmr_q), int'(base));
        strobe(7);
        chk("R5", "strobe source 1:1", int'(tmr_q), int'(base) + 7);
    endtask

    task automatic t_prescale(input logic [2:0] rate);
        int ratio;
        ratio = 2 << rate;
        set_cfg(1'b0, 1'b0, 1'b0, rate);
        write_tmr('0);
        strobe(ratio - 1);
        chk("R4", $sformatf("no step before ratio %0d", ratio), int'(tmr_q), 0);
        strobe(1);
        chk("R4", $sformatf("step at ratio %0d", ratio), int'(tmr_q), 1);
        strobe(ratio * 3);
        chk("R4", $sformatf("three more at ratio %0d", ratio), int'(tmr_q), 4);
    endtask

    task automatic t_overflow;
        set_cfg(1'b0, 1'b0, 1'b1, 3'd0);
        write_tmr(8'hFE);
        chk("R7", "load value", int'(tmr_q), 254);
        strobe(1);
        chk("R6", "step to FF", int'(tmr_q), 255);
        chk("R6", "no pulse at FF", int'(tmr_ovf), 0);
        strobe(1);
        chk("R6", "wrap to 00", int'(tmr_q), 0);
        chk("R6", "overflow pulse", int'(tmr_ovf), 1);
        @(negedge clk);
        chk("R6", "overflow pulse one cycle", int'(tmr_ovf), 0);
    endtask

    task automatic t_write_clears;
        set_cfg(1'b0, 1'b0, 1'b0, 3'd1);
        write_tmr('0);
        strobe(3);
        chk("R7", "partial prescale", int'(tmr_q), 0);
        write_tmr(8'd10);
        strobe(3);
        chk("R7", "prescale emptied by write", int'(tmr_q), 10);
        strobe(1);
        chk("R7", "step after full ratio", int'(tmr_q), 11);
    endtask

    task automatic t_wdt_plain;
        int seen;
        set_cfg(1'b0, 1'b0, 1'b0, 3'd5);
        kick(1'b0);
        chk("R10", "clear sets to_n", int'(wdt_to_n), 1);
        ticks(WDT_N - 1, seen);
        chk("R9", "no time-out before 16 ticks", seen, 0);
        ticks(1, seen);
        chk("R8", "time-out at 16 ticks", seen, 1);
        chk("R8", "to_n low", int'(wdt_to_n), 0);
        kick(1'b0);
        chk("R10", "clear restores to_n", int'(wdt_to_n), 1);
        ticks(10, seen);
        kick(1'b1);
        chk("R10", "sleep keeps to_n high", int'(wdt_to_n), 1);
        ticks(WDT_N - 1, seen);
        chk("R10", "sleep restarted count", seen, 0);
        ticks(1, seen);
        chk("R10", "time-out after restart", seen, 1);
    endtask

    task automatic t_wdt_prescaled(input logic [2:0] rate);
        int seen;
        int ratio;
        ratio = 1 << rate;
        set_cfg(1'b0, 1'b0, 1'b1, rate);
        ticks(3, seen);
        kick(1'b0);
        ticks(ratio * WDT_N - 1, seen);
        chk("R9", $sformatf("no time-out at ratio %0d", ratio), seen, 0);
        ticks(1, seen);
        chk("R10", $sformatf("kick emptied prescaler, ratio %0d", ratio), seen, 1);
    endtask

    initial begin
        t_reset();
        t_reset_wdt_rate();
        t_source_edge();
        t_prescale(3'd0);
        t_prescale(3'd2);
        t_prescale(3'd7);
        t_overflow();
        t_write_clears();
        t_wdt_plain();
        t_wdt_prescaled(3'd2);
        t_wdt_prescaled(3'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule